// File: doc/BRIEF.md
# Frame Statistics Counter Bank

The bank sits beside an Ethernet MAC. It takes one end-of-frame event record per frame and turns it into statistics. Each record carries the frame length, the direction (receive or transmit) and a byte of type and error flags. From these the bank keeps several kinds of counters:

- per-category frame counters;
- one total frame counter per direction;
- a seven-bin length histogram for each direction;
- one wide byte accumulator per direction.

Software reads the counters through a simple address/data read port. A read returns a counter's value and zeroes that counter in the same step. A global clear input zeroes everything at once. No counter ever wraps; each one stops at its maximum value.

Each byte accumulator is wider than a data word, so it is read in two halves. Reading the low half clears the accumulator and copies its upper bits into a hold register. A later read of the high half returns that held copy, so the two halves always belong to the same instant.

The oversize counter's word has a different layout. Its top bit is a separate flag that reports that the counter overflowed its range.

Top module: `stats_counter_bank`

## Requirements
- R1: After reset, and in the cycle after `clr_all` is high, every counter, the oversize flag and both high-half hold registers are zero.
- R2: A read is requested by holding `rd_en` high for one cycle with `rd_addr` set. In the next cycle `rd_valid` is high and `rd_data` holds the addressed word as it stood before that edge. `rd_valid` is low after every cycle with no request.
- R3: Address map. Receive byte counter low/high half at 0/1, transmit byte counter low/high half at 2/3. Receive total frames at 4. Receive categories at 5 to 12: multicast, broadcast, pause, FCS error, symbol error, short, jabber, oversize. Receive length bins at 13 to 19. Transmit total frames at 20. Transmit categories at 21 to 24: multicast, broadcast, pause, error. Transmit length bins at 25 to 31.
- R4: A receive event increments the receive total and each receive category whose flag is set. The flag bits of `ev_flags` are: bit0 multicast, bit1 broadcast, bit2 pause, bit3 FCS error (receive) or error (transmit), bit4 symbol error, bit5 short, bit6 jabber, bit7 oversize.
- R5: A transmit event increments the transmit total and the transmit multicast, broadcast, pause and error counters from flag bits 0 to 3. Flag bits 4 to 7 have no effect on a transmit event, and a transmit event changes no receive counter.
- R6: Each event whose length is 64 or more increments exactly one length bin of its direction. The bins are: 64; 65 to 127; 128 to 255; 256 to 511; 512 to 1023; 1024 to 1518; 1519 and above. A length below 64 touches no bin.
- R7: Each event adds its length to its direction's byte counter, which is BYTE_W bits wide. The low half (LO_W bits) is read at the low address. Reading the low half clears the counter and latches the upper bits. Reading the high half returns that latched value and clears nothing.
- R8: Reading any frame counter word or byte low half zeroes that counter.
- R9: An event in the same cycle as a clearing read of its counter, or as `clr_all`, is counted after the clear, so the counter then holds the new event alone.
- R10: Every counter saturates at its all-ones value instead of wrapping.
- R11: The oversize word has its count in the low CNT_W-1 bits and a flag in bit 31. The flag sets when an oversize event arrives while the count is at its maximum. A read of that word clears both the count and the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | End-of-frame event strobe |
| ev_tx | input | 1 | Event direction: 1 transmit, 0 receive |
| ev_len | input | LEN_W | Frame length in bytes |
| ev_flags | input | 8 | Frame type and error flags (see R4) |
| clr_all | input | 1 | Zero all counters |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_data | output | DATA_W | Read data, one cycle after request |
| rd_valid | output | 1 | Read data valid |

## Verification
A wrongly decoded event shows up at the next read of the affected word. A missed bin or a doubled category gives a count one off, and a transmit flag that leaks into receive counters gives a nonzero receive word. A broken clear-on-read or a lost same-cycle event shows on the second read of a word, one read cycle later. A stale or unlatched high half shows as a byte total that disagrees with the sum of the lengths sent. Saturation and flag errors appear only after the counter reaches its maximum, so the bench shrinks the widths to make that limit reachable within a few hundred events.

// File: rtl/stats_pkg.sv
package stats_pkg;

  // flag bit positions in the event record
  localparam int FL_MCAST = 0;
  localparam int FL_BCAST = 1;
  localparam int FL_PAUSE = 2;
  localparam int FL_ERR   = 3;
  localparam int FL_SYM   = 4;
  localparam int FL_SHORT = 5;
  localparam int FL_JAB   = 6;
  localparam int FL_OVS   = 7;
  localparam int FLAG_W   = 8;

  localparam int BKT_N = 7;

  // frame counter indices
  localparam int IX_RX_FRAMES = 0;
  localparam int IX_RX_MCAST  = 1;
  localparam int IX_RX_BCAST  = 2;
  localparam int IX_RX_PAUSE  = 3;
  localparam int IX_RX_FCS    = 4;
  localparam int IX_RX_SYM    = 5;
  localparam int IX_RX_SHORT  = 6;
  localparam int IX_RX_JAB    = 7;
  localparam int IX_RX_OVS    = 8;
  localparam int IX_RX_BKT0   = 9;
  localparam int NUM_RX       = IX_RX_BKT0 + BKT_N;
  localparam int IX_TX_FRAMES = NUM_RX;
  localparam int IX_TX_MCAST  = NUM_RX + 1;
  localparam int IX_TX_BCAST  = NUM_RX + 2;
  localparam int IX_TX_PAUSE  = NUM_RX + 3;
  localparam int IX_TX_ERR    = NUM_RX + 4;
  localparam int IX_TX_BKT0   = NUM_RX + 5;
  localparam int NUM_FRM      = IX_TX_BKT0 + BKT_N;
  localparam int NUM_TX       = NUM_FRM - NUM_RX;

  // word address map
  localparam int A_RXB_LO  = 0;
  localparam int A_RXB_HI  = 1;
  localparam int A_TXB_LO  = 2;
  localparam int A_TXB_HI  = 3;
  localparam int A_FRM0    = 4;
  localparam int NUM_WORDS = A_FRM0 + NUM_FRM;

  // a length of 64 or more lands in exactly one bin
  function automatic logic len_binned(input logic [31:0] len);
    return len >= 32'd64;
  endfunction

  function automatic int len_bin(input logic [31:0] len);
    if (len <= 32'd64)        return 0;
    else if (len < 32'd128)   return 1;
    else if (len < 32'd256)   return 2;
    else if (len < 32'd512)   return 3;
    else if (len < 32'd1024)  return 4;
    else if (len < 32'd1519)  return 5;
    else                      return 6;
  endfunction

endpackage

// File: rtl/stats_event_decode.sv
module stats_event_decode
  import stats_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic                ev_valid,
  input  logic                ev_tx,
  input  logic [LEN_W-1:0]    ev_len,
  input  logic [FLAG_W-1:0]   ev_flags,
  output logic [NUM_FRM-1:0]  inc_vec
);

  logic [31:0] len32;
  logic        binned;
  int          bin;

  assign len32  = 32'(ev_len);
  assign binned = len_binned(len32);
  assign bin    = len_bin(len32);

  always_comb begin
    inc_vec = '0;
    if (ev_valid) begin
      if (!ev_tx) begin
        inc_vec[IX_RX_FRAMES] = 1'b1;
        inc_vec[IX_RX_MCAST]  = ev_flags[FL_MCAST];
        inc_vec[IX_RX_BCAST]  = ev_flags[FL_BCAST];
        inc_vec[IX_RX_PAUSE]  = ev_flags[FL_PAUSE];
        inc_vec[IX_RX_FCS]    = ev_flags[FL_ERR];
        inc_vec[IX_RX_SYM]    = ev_flags[FL_SYM];
        inc_vec[IX_RX_SHORT]  = ev_flags[FL_SHORT];
        inc_vec[IX_RX_JAB]    = ev_flags[FL_JAB];
        inc_vec[IX_RX_OVS]    = ev_flags[FL_OVS];
        if (binned) inc_vec[IX_RX_BKT0 + bin] = 1'b1;
      end else begin
        inc_vec[IX_TX_FRAMES] = 1'b1;
        inc_vec[IX_TX_MCAST]  = ev_flags[FL_MCAST];
        inc_vec[IX_TX_BCAST]  = ev_flags[FL_BCAST];
        inc_vec[IX_TX_PAUSE]  = ev_flags[FL_PAUSE];
        inc_vec[IX_TX_ERR]    = ev_flags[FL_ERR];
        if (binned) inc_vec[IX_TX_BKT0 + bin] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/stats_sat_counter.sv
module stats_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         glb_clr,
  input  logic         rd_clr,
  input  logic         inc,
  output logic [W-1:0] value
);

  localparam logic [W-1:0] MAXV = '1;

  function automatic logic [W-1:0] next_val(input logic [W-1:0] cur,
                                             input logic clr, input logic up);
    if (clr)                   return up ? W'(1) : '0;
    else if (up && cur != MAXV) return cur + W'(1);
    else                       return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) value <= '0;
    else        value <= next_val(value, glb_clr | rd_clr, inc);
  end

endmodule

// File: rtl/stats_byte_counter.sv
module stats_byte_counter #(
  parameter int LEN_W  = 16,
  parameter int BYTE_W = 45,
  parameter int LO_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              glb_clr,
  input  logic              rd_lo,
  input  logic              add_en,
  input  logic [LEN_W-1:0]  add_len,
  output logic [LO_W-1:0]   lo_val,
  output logic [BYTE_W-LO_W-1:0] hi_hold
);

  localparam int HI_W = BYTE_W - LO_W;

  logic [BYTE_W-1:0] acc;

  function automatic logic [BYTE_W-1:0] sat_add(input logic [BYTE_W-1:0] a,
                                                 input logic [LEN_W-1:0] b);
    logic [BYTE_W:0] s;
    s = {1'b0, a} + (BYTE_W+1)'(b);
    return s[BYTE_W] ? '1 : s[BYTE_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      hi_hold <= '0;
    end else begin
      if (glb_clr || rd_lo) acc <= add_en ? BYTE_W'(add_len) : '0;
      else if (add_en)      acc <= sat_add(acc, add_len);
      if (glb_clr)          hi_hold <= '0;
      else if (rd_lo)       hi_hold <= acc[BYTE_W-1:LO_W];
    end
  end

  assign lo_val = acc[LO_W-1:0];

endmodule

// File: rtl/stats_counter_bank.sv
module stats_counter_bank
  import stats_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 32,
  parameter int BYTE_W = 45,
  parameter int LO_W   = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic              ev_tx,
  input  logic [LEN_W-1:0]  ev_len,
  input  logic [7:0]        ev_flags,
  input  logic              clr_all,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  localparam int HI_W    = BYTE_W - LO_W;
  localparam int OVS_W   = CNT_W - 1;
  localparam int ADDR_N  = 2 ** ADDR_W;

  // named internal events
  logic [NUM_FRM-1:0] inc_vec;
  logic [NUM_FRM-1:0] rd_clr_vec;
  logic               rd_rxb_lo, rd_txb_lo;
  logic               ev_rx, ev_txd;
  logic [LO_W-1:0]    rxb_lo, txb_lo;
  logic [HI_W-1:0]    rxb_hi_hold, txb_hi_hold;
  logic [OVS_W-1:0]   ovs_cnt;
  logic               ovs_hit;
  logic               ovs_flag;
  logic [CNT_W-1:0]   rx_frames_cnt;
  logic               frm_any_nz;

  logic [DATA_W-1:0]  frm_word [NUM_FRM];
  logic [DATA_W-1:0]  word_arr [ADDR_N];

  stats_event_decode #(.LEN_W(LEN_W)) dec_i (
    .ev_valid (ev_valid),
    .ev_tx    (ev_tx),
    .ev_len   (ev_len),
    .ev_flags (ev_flags),
    .inc_vec  (inc_vec)
  );

  assign ev_rx     = ev_valid && !ev_tx;
  assign ev_txd    = ev_valid &&  ev_tx;
  assign rd_rxb_lo = rd_en && (rd_addr == ADDR_W'(A_RXB_LO));
  assign rd_txb_lo = rd_en && (rd_addr == ADDR_W'(A_TXB_LO));

  stats_byte_counter #(.LEN_W(LEN_W), .BYTE_W(BYTE_W), .LO_W(LO_W)) rxb_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .glb_clr (clr_all),
    .rd_lo   (rd_rxb_lo),
    .add_en  (ev_rx),
    .add_len (ev_len),
    .lo_val  (rxb_lo),
    .hi_hold (rxb_hi_hold)
  );

  stats_byte_counter #(.LEN_W(LEN_W), .BYTE_W(BYTE_W), .LO_W(LO_W)) txb_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .glb_clr (clr_all),
    .rd_lo   (rd_txb_lo),
    .add_en  (ev_txd),
    .add_len (ev_len),
    .lo_val  (txb_lo),
    .hi_hold (txb_hi_hold)
  );

  for (genvar i = 0; i < NUM_FRM; i++) begin : g_frm
    assign rd_clr_vec[i] = rd_en && (rd_addr == ADDR_W'(A_FRM0 + i));
    if (i == IX_RX_OVS) begin : g_ovs
      stats_sat_counter #(.W(OVS_W)) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .glb_clr (clr_all),
        .rd_clr  (rd_clr_vec[i]),
        .inc     (inc_vec[i]),
        .value   (ovs_cnt)
      );
      always_comb begin
        frm_word[i]           = '0;
        frm_word[i][OVS_W-1:0] = ovs_cnt;
        frm_word[i][DATA_W-1] = ovs_flag;
      end
    end else begin : g_std
      logic [CNT_W-1:0] val;
      stats_sat_counter #(.W(CNT_W)) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .glb_clr (clr_all),
        .rd_clr  (rd_clr_vec[i]),
        .inc     (inc_vec[i]),
        .value   (val)
      );
      assign frm_word[i] = DATA_W'(val);
    end
    assign word_arr[A_FRM0 + i] = frm_word[i];
  end

  for (genvar j = NUM_WORDS; j < ADDR_N; j++) begin : g_pad
    assign word_arr[j] = '0;
  end

  assign word_arr[A_RXB_LO] = DATA_W'(rxb_lo);
  assign word_arr[A_RXB_HI] = DATA_W'(rxb_hi_hold);
  assign word_arr[A_TXB_LO] = DATA_W'(txb_lo);
  assign word_arr[A_TXB_HI] = DATA_W'(txb_hi_hold);

  // oversize overflow flag: an event that meets a full count
  assign ovs_hit = inc_vec[IX_RX_OVS] && !clr_all && !rd_clr_vec[IX_RX_OVS]
                   && (ovs_cnt == '1);

  always_ff @(posedge clk) begin
    if (!rst_n)                               ovs_flag <= 1'b0;
    else if (clr_all || rd_clr_vec[IX_RX_OVS]) ovs_flag <= 1'b0;
    else if (ovs_hit)                         ovs_flag <= 1'b1;
  end

  assign rx_frames_cnt = frm_word[IX_RX_FRAMES][CNT_W-1:0];

  always_comb begin
    frm_any_nz = 1'b0;
    for (int k = 0; k < NUM_FRM; k++) frm_any_nz = frm_any_nz | (|frm_word[k]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= word_arr[rd_addr];
    end
  end

endmodule

// File: rtl/stats_counter_bank_chk.sv
module stats_counter_bank_chk
  import stats_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int HI_W   = 13,
  parameter int ADDR_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clr_all,
  input logic               ev_valid,
  input logic               ev_tx,
  input logic               rd_en,
  input logic [ADDR_W-1:0]  rd_addr,
  input logic               rd_valid,
  input logic [NUM_FRM-1:0] inc_vec,
  input logic [CNT_W-1:0]   rx_frames_cnt,
  input logic [HI_W-1:0]    rxb_hi_hold,
  input logic               frm_any_nz
);

  logic rd_rxf, rd_rxlo;
  assign rd_rxf  = rd_en && (rd_addr == ADDR_W'(A_FRM0 + IX_RX_FRAMES));
  assign rd_rxlo = rd_en && (rd_addr == ADDR_W'(A_RXB_LO));

  AST_RD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R2
  AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid); // R2
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && !ev_valid) |=> !frm_any_nz); // R1
  AST_RX_ONE_BIN: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(inc_vec[IX_RX_BKT0 +: BKT_N])); // R6
  AST_TX_ONE_BIN: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(inc_vec[IX_TX_BKT0 +: BKT_N])); // R6
  AST_DIR_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !((|inc_vec[0 +: NUM_RX]) && (|inc_vec[NUM_RX +: NUM_TX]))); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_frames_cnt == '1 && !clr_all && !rd_rxf) |=> rx_frames_cnt == '1); // R10
  AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_rxlo && !clr_all) |=> $stable(rxb_hi_hold)); // R7
  AST_EV_AFTER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && ev_valid && !ev_tx) |=> rx_frames_cnt == CNT_W'(1)); // R9

endmodule

bind stats_counter_bank stats_counter_bank_chk #(
  .CNT_W  (CNT_W),
  .HI_W   (BYTE_W - LO_W),
  .ADDR_W (ADDR_W)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .clr_all       (clr_all),
  .ev_valid      (ev_valid),
  .ev_tx         (ev_tx),
  .rd_en         (rd_en),
  .rd_addr       (rd_addr),
  .rd_valid      (rd_valid),
  .inc_vec       (inc_vec),
  .rx_frames_cnt (rx_frames_cnt),
  .rxb_hi_hold   (rxb_hi_hold),
  .frm_any_nz    (frm_any_nz)
);

// File: tb/stats_counter_bank_tb_top.sv
`timescale 1ns/1ps
module stats_counter_bank_tb_top;

  localparam int LEN_W = 14;
  localparam int CNT_W = 8;
  localparam int BYTE_W = 13;
  localparam int LO_W = 8;
  localparam int ADDR_W = 5;

  // address map from R3
  localparam int RXB_LO = 0, RXB_HI = 1, TXB_LO = 2, TXB_HI = 3;
  localparam int RXF = 4, RXMC = 5, RXBC = 6, RXPA = 7, RXFCS = 8;
  localparam int RXSYM = 9, RXSHORT = 10, RXJAB = 11, RXOVS = 12, RXBK0 = 13;
  localparam int TXF = 20, TXMC = 21, TXBC = 22, TXPA = 23, TXERR = 24, TXBK0 = 25;
  // flag bits from R4
  localparam logic [7:0] F_MC = 8'h01, F_BC = 8'h02, F_PA = 8'h04, F_ER = 8'h08;
  localparam logic [7:0] F_SY = 8'h10, F_SH = 8'h20, F_JB = 8'h40, F_OV = 8'h80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 1'b0, ev_tx = 1'b0, clr_all = 1'b0, rd_en = 1'b0;
  logic [LEN_W-1:0] ev_len = '0;
  logic [7:0] ev_flags = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic rd_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  stats_counter_bank #(
    .LEN_W(LEN_W), .CNT_W(CNT_W), .BYTE_W(BYTE_W), .LO_W(LO_W),
    .DATA_W(32), .ADDR_W(ADDR_W)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_tx(ev_tx),
    .ev_len(ev_len), .ev_flags(ev_flags), .clr_all(clr_all),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic send(input logic tx, input int len, input logic [7:0] fl);
    @(negedge clk);
    ev_valid = 1'b1; ev_tx = tx; ev_len = LEN_W'(len); ev_flags = fl;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = ADDR_W'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
    check("R2 rd_valid", 32'(rd_valid), 32'd1);
  endtask

  task automatic expect_rd(input string tag, input int a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic clear();
    @(negedge clk); clr_all = 1'b1;
    @(negedge clk); clr_all = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R2 rd_valid idle", 32'(rd_valid), 32'd0);
    for (int a = 0; a < 32; a++) expect_rd("R1 reset word", a, 32'd0);
  endtask

  task automatic t_rx_cat();
    clear();
    send(1'b0, 100, F_MC);
    send(1'b0, 64, F_BC | F_PA);
    send(1'b0, 40, F_SH | F_ER);
    send(1'b0, 2000, F_JB | F_OV | F_SY);
    expect_rd("R4 rx frames", RXF, 4);
    expect_rd("R4 rx mcast", RXMC, 1);
    expect_rd("R4 rx bcast", RXBC, 1);
    expect_rd("R4 rx pause", RXPA, 1);
    expect_rd("R4 rx fcs", RXFCS, 1);
    expect_rd("R4 rx sym", RXSYM, 1);
    expect_rd("R4 rx short", RXSHORT, 1);
    expect_rd("R4 rx jabber", RXJAB, 1);
    expect_rd("R11 rx ovs one", RXOVS, 1);
    expect_rd("R6 rx bin 64", RXBK0, 1);
    expect_rd("R6 rx bin 65-127", RXBK0 + 1, 1);
    expect_rd("R6 rx bin 1519+", RXBK0 + 6, 1);
    expect_rd("R3 rx bytes hi before lo", RXB_HI, 0);
    expect_rd("R7 rx bytes lo", RXB_LO, 2204 % 256);
    expect_rd("R7 rx bytes hi", RXB_HI, 2204 / 256);
    expect_rd("R5 tx frames untouched", TXF, 0);
  endtask

  task automatic t_bins();
    int lens[13] = '{63, 64, 65, 127, 128, 255, 256, 511, 512, 1023, 1024, 1518, 1519};
    int exp[7] = '{1, 2, 2, 2, 2, 2, 1};
    clear();
    foreach (lens[k]) send(1'b0, lens[k], 8'h00);
    for (int b = 0; b < 7; b++) expect_rd("R6 rx bin boundary", RXBK0 + b, exp[b]);
    expect_rd("R6 rx frames incl short", RXF, 13);
  endtask

  task automatic t_tx();
    clear();
    send(1'b1, 200, F_MC | F_SY | F_SH | F_JB | F_OV);
    send(1'b1, 1600, F_BC | F_PA | F_ER);
    expect_rd("R5 tx frames", TXF, 2);
    expect_rd("R5 tx mcast", TXMC, 1);
    expect_rd("R5 tx bcast", TXBC, 1);
    expect_rd("R5 tx pause", TXPA, 1);
    expect_rd("R5 tx err", TXERR, 1);
    expect_rd("R6 tx bin 128-255", TXBK0 + 2, 1);
    expect_rd("R6 tx bin 1519+", TXBK0 + 6, 1);
    expect_rd("R5 rx frames untouched", RXF, 0);
    expect_rd("R5 rx sym ignored", RXSYM, 0);
    expect_rd("R5 rx ovs ignored", RXOVS, 0);
    expect_rd("R5 rx bytes untouched", RXB_LO, 0);
    expect_rd("R7 tx bytes lo", TXB_LO, 1800 % 256);
    expect_rd("R7 tx bytes hi", TXB_HI, 1800 / 256);
  endtask

  task automatic t_clr_on_read();
    clear();
    repeat (3) send(1'b0, 70, F_MC);
    expect_rd("R8 mcast first read", RXMC, 3);
    expect_rd("R8 mcast second read", RXMC, 0);
    expect_rd("R8 bin first read", RXBK0 + 1, 3);
    expect_rd("R8 bin second read", RXBK0 + 1, 0);
    expect_rd("R8 rx frames first", RXF, 3);
    expect_rd("R8 rx frames second", RXF, 0);
    expect_rd("R8 bytes lo first", RXB_LO, 210);
    expect_rd("R8 bytes lo second", RXB_LO, 0);
  endtask

  task automatic t_same_cycle();
    clear();
    send(1'b0, 10, 8'h00);
    send(1'b0, 10, 8'h00);
    @(negedge clk);
    ev_valid = 1'b1; ev_tx = 1'b0; ev_len = LEN_W'(10); ev_flags = 8'h00;
    rd_en = 1'b1; rd_addr = ADDR_W'(RXF);
    @(negedge clk);
    ev_valid = 1'b0; rd_en = 1'b0;
    check("R9 read with event returns old", rd_data, 2);
    expect_rd("R9 event kept after read", RXF, 1);
    @(negedge clk);
    ev_valid = 1'b1; ev_len = LEN_W'(5);
    rd_en = 1'b1; rd_addr = ADDR_W'(RXB_LO);
    @(negedge clk);
    ev_valid = 1'b0; rd_en = 1'b0;
    check("R9 bytes lo with event", rd_data, 30);
    expect_rd("R9 bytes event kept", RXB_LO, 5);
    @(negedge clk);
    ev_valid = 1'b1; ev_len = LEN_W'(7); clr_all = 1'b1;
    @(negedge clk);
    ev_valid = 1'b0; clr_all = 1'b0;
    expect_rd("R9 event kept after clr_all", RXF, 1);
    expect_rd("R9 bytes after clr_all", RXB_LO, 7);
  endtask

  task automatic t_hi_latch();
    clear();
    send(1'b0, 300, 8'h00);
    expect_rd("R7 hi not latched yet", RXB_HI, 0);
    expect_rd("R7 lo latches", RXB_LO, 300 % 256);
    expect_rd("R7 hi latched", RXB_HI, 1);
    send(1'b0, 600, 8'h00);
    expect_rd("R7 hi held again", RXB_HI, 1);
    expect_rd("R7 lo after clear", RXB_LO, 600 % 256);
    expect_rd("R7 hi new snapshot", RXB_HI, 2);
    send(1'b1, 20, F_PA);
    clear();
    expect_rd("R1 hi hold cleared", RXB_HI, 0);
    expect_rd("R1 tx pause cleared", TXPA, 0);
    expect_rd("R1 tx frames cleared", TXF, 0);
  endtask

  task automatic t_saturate();
    clear();
    repeat (260) send(1'b0, 64, F_MC);
    repeat (6) send(1'b1, 1500, 8'h00);
    expect_rd("R10 rx frames sat", RXF, 255);
    expect_rd("R10 rx mcast sat", RXMC, 255);
    expect_rd("R10 rx bin sat", RXBK0, 255);
    expect_rd("R10 rx bytes lo sat", RXB_LO, 255);
    expect_rd("R10 rx bytes hi sat", RXB_HI, 31);
    expect_rd("R10 tx bytes lo sat", TXB_LO, 255);
    expect_rd("R10 tx bytes hi sat", TXB_HI, 31);
    expect_rd("R10 tx bin 1024-1518", TXBK0 + 5, 6);
  endtask

  task automatic t_oversize();
    clear();
    repeat (127) send(1'b0, 2000, F_OV);
    expect_rd("R11 ovs full no flag", RXOVS, 32'h0000_007F);
    repeat (129) send(1'b0, 2000, F_OV);
    expect_rd("R11 ovs flag set", RXOVS, 32'h8000_007F);
    expect_rd("R11 ovs cleared by read", RXOVS, 0);
    expect_rd("R11 jabber untouched", RXJAB, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rx_cat();
    t_bins();
    t_tx();
    t_clr_on_read();
    t_same_cycle();
    t_hi_latch();
    t_saturate();
    t_oversize();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule